// File: doc/BRIEF.md
# SPI Serial Memory Command Controller

This block is the slave-side command engine of a byte-addressed serial memory with 32768 locations. It watches the chip-select, serial clock, serial data-in and pause inputs. It assembles an 8-bit command, collects the address that follows a read or a write, and then does one of two things. For reads it streams bytes onto the serial output from a combinational memory read port, moving to the next address after each byte. For writes it hands each received data byte to an external page buffer. The storage array, the page buffer, the status register and the write-enable latch all sit outside the block. The block reaches them through single-cycle strobes and the `memAddr`, `wrData` and `statusIn` buses.

All serial inputs are sampled on the rising edge of `clk`. The block finds serial clock edges by comparing `sck` with its value one cycle earlier. Each `sck` level must therefore stay stable for at least two `clk` cycles. Every strobe output is registered. It is high for exactly one `clk` cycle, in the cycle that follows the sample at which the triggering serial event was seen. The three-state serial output is modelled as a data bit `so` plus an output enable `soEn`.

Top module: `spi_mem_cmd`

## Requirements
- R1: The input bit on `si` is taken at each rising `sck` edge, most significant bit first. Command bytes are decoded as 0x06 set-write-enable, 0x04 clear-write-enable, 0x05 status read, 0x01 status write, 0x03 array read and 0x02 array write.
- R2: In an output phase, each falling `sck` edge places the next output bit on `so`, most significant bit first. The first falling edge after the last command or address bit places bit 7 of the first byte. `soEn` is high only in an output phase while `csN` is low and no pause is active.
- R3: A falling `csN` starts a new command byte. While `csN` is high, `soEn` is low and the transaction state is cleared.
- R4: Array read and array write are each followed by two address bytes, high byte first. Bit 7 of the first address byte is ignored, and the remaining 15 bits form `memAddr`.
- R5: During an array read, `memAddr` increases by one after each output byte and wraps from 0x7FFF to 0x0000.
- R6: `wenSet` pulses once after `csN` rises, and only if exactly eight rising edges followed the select and they carried 0x06. It does not pulse before `csN` rises.
- R7: `wenClr` pulses right after the eighth bit of a 0x04 command.
- R8: A 0x05 command pulses `statusRd` and then repeats the `statusIn` byte on `so` for as long as clocks arrive.
- R9: After a 0x01 command, `statusWr` pulses when `csN` rises, and only if exactly one full data byte followed the command. That byte appears on `wrData`.
- R10: After an array write address, each full data byte pulses `wrValid` with the byte on `wrData` and its address on `memAddr`. The address then increments. `wrCommit` pulses when `csN` rises, and only if at least one byte arrived and no partial byte is pending.
- R11: A falling `holdN` while `sck` is low pauses the transfer. While paused, `sck` and `si` activity is ignored and `soEn` is low. A rising `holdN` while `sck` is low resumes at the same bit.
- R12: An unrecognised command byte is ignored until `csN` rises. No strobe pulses and `soEn` stays low.
- R13: While `busy` is high when a command byte completes, only 0x05 is honoured. Every other command is treated as unrecognised.
- R14: Transfers work both with `sck` idle low at select (mode 0) and with `sck` idle high at select (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples all serial inputs |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| holdN | input | 1 | Active-low transfer pause |
| busy | input | 1 | Internal write cycle in progress |
| memRdData | input | 8 | Combinational read data at `memAddr` |
| statusIn | input | 8 | Status byte to send on a status read |
| so | output | 1 | Serial data out |
| soEn | output | 1 | Output enable for `so` |
| memAddr | output | 15 | Current read or write address |
| wrValid | output | 1 | Write data byte strobe |
| wrData | output | 8 | Received write or status-write byte |
| wrCommit | output | 1 | Start of internal write cycle |
| wenSet | output | 1 | Set write-enable latch |
| wenClr | output | 1 | Clear write-enable latch |
| statusRd | output | 1 | Status read started |
| statusWr | output | 1 | Status write accepted |

## Verification
Reads are tried in both clock idle levels and from an address whose discarded top bit is set. This tells address capture apart from byte-order and mode handling. A run across 0x7FFF shows the wrap. Writes and write-enable commands are ended on a byte boundary, one bit late, and part-way through a byte. This separates real commits from premature or stray ones. Pauses placed mid-byte with junk clocks during both a read and a write show that no bit is lost or repeated. Runs with `busy` high, and with an unused command byte, check that only the status read still produces output.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WRDI  = 8'h04;
  localparam logic [BYTE_W-1:0] OP_RDSR  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WRSR  = 8'h01;
  localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;
  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;

  typedef enum logic [3:0] {
    ST_IDLE,      // collecting command byte
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_STATUS,
    ST_WRSR,
    ST_SRDONE,
    ST_WREN_WAIT,
    ST_IGNORE
  } cmdState_t;

  typedef struct packed {
    logic shiftIn;
    logic capAddr;
    logic incAddr;
    logic loadOut;
    logic shiftOut;
    logic latchData;
    logic srcStatus;
  } dpStrobe_t;

endpackage

// File: rtl/spimem_dp.sv
module spimem_dp
  import spimem_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              si,
  input  dpStrobe_t         strb,
  input  logic [BYTE_W-1:0] memRdData,
  input  logic [BYTE_W-1:0] statusIn,
  output logic [BYTE_W-1:0] nextByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic              so,
  output logic [BYTE_W-1:0] wrData
);

  logic [BYTE_W-1:0]        inShift;
  logic [ADDR_W-1:0]        addr;
  logic [BYTE_W-2:0]        outShift;
  logic                     soQ;
  logic [BYTE_W-1:0]        wrDataQ;
  logic [ADDR_W+BYTE_W-1:0] addrCat;
  logic [BYTE_W-1:0]        outSrc;

  assign nextByte = {inShift[BYTE_W-2:0], si};
  assign addrCat  = {addr, nextByte};
  assign outSrc   = strb.srcStatus ? statusIn : memRdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      addr     <= '0;
      outShift <= '0;
      soQ      <= 1'b0;
      wrDataQ  <= '0;
    end else begin
      if (strb.shiftIn) inShift <= nextByte;
      if (strb.capAddr)      addr <= addrCat[ADDR_W-1:0];
      else if (strb.incAddr) addr <= addr + ADDR_W'(1);
      if (strb.loadOut)       {soQ, outShift} <= outSrc;
      else if (strb.shiftOut) {soQ, outShift} <= {outShift, 1'b0};
      if (strb.latchData) wrDataQ <= nextByte;
    end
  end

  assign memAddr = addr;
  assign so      = soQ;
  assign wrData  = wrDataQ;

  // capture and increment come from separate control terms; never together
  assert_addr_ops_disjoint_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.capAddr && strb.incAddr));

  assert_out_ops_disjoint_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadOut && strb.shiftIn));

endmodule

// File: rtl/spimem_ctrl.sv
module spimem_ctrl
  import spimem_pkg::*;
#(
  parameter int ADDR_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              holdN,
  input  logic              busy,
  input  logic [BYTE_W-1:0] nextByte,
  output dpStrobe_t         strb,
  output logic              soEn,
  output logic              wrValid,
  output logic              wrCommit,
  output logic              wenSet,
  output logic              wenClr,
  output logic              statusRd,
  output logic              statusWr
);

  localparam int ABW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [ABW-1:0] LAST_AB = ABW'(ADDR_BYTES - 1);

  cmdState_t      state;
  logic           sckQ, holdQ, held;
  logic [2:0]     bitCnt, outCnt;
  logic [ABW-1:0] abCnt;
  logic           isWrite, gotByte;
  logic           active, sRise, sFall, byteDone, outPhase;

  assign active   = !csN && !held;
  assign sRise    = active && sck && !sckQ;
  assign sFall    = active && !sck && sckQ;
  assign byteDone = sRise && (bitCnt == 3'd7);
  assign outPhase = (state == ST_RDATA) || (state == ST_STATUS);
  assign soEn     = outPhase && active;

  always_comb begin
    strb           = '0;
    strb.shiftIn   = sRise;
    strb.capAddr   = byteDone && (state == ST_ADDR);
    strb.latchData = byteDone && ((state == ST_WDATA) || (state == ST_WRSR));
    strb.loadOut   = sFall && outPhase && (outCnt == 3'd0);
    strb.shiftOut  = sFall && outPhase && (outCnt != 3'd0);
    strb.srcStatus = (state == ST_STATUS);
    strb.incAddr   = wrValid || (sFall && (state == ST_RDATA) && (outCnt == 3'd7));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      sckQ <= 1'b0; holdQ <= 1'b1; held <= 1'b0;
      bitCnt <= '0; outCnt <= '0; abCnt <= '0;
      isWrite <= 1'b0; gotByte <= 1'b0;
      wrValid <= 1'b0; wrCommit <= 1'b0; wenSet <= 1'b0;
      wenClr <= 1'b0; statusRd <= 1'b0; statusWr <= 1'b0;
    end else begin
      sckQ     <= sck;
      holdQ    <= holdN;
      wrValid  <= 1'b0;
      wenClr   <= 1'b0;
      statusRd <= 1'b0;
      if (csN)                                 held <= 1'b0;
      else if (!held && holdQ && !holdN && !sck) held <= 1'b1;
      else if (held && holdN && !sck)          held <= 1'b0;

      if (csN) begin
        // end-of-select decisions use the state left by the transfer
        wenSet   <= (state == ST_WREN_WAIT);
        statusWr <= (state == ST_SRDONE);
        wrCommit <= (state == ST_WDATA) && (bitCnt == 3'd0) && gotByte;
        state    <= ST_IDLE;
        bitCnt   <= '0;
        outCnt   <= '0;
        abCnt    <= '0;
        gotByte  <= 1'b0;
      end else begin
        wenSet   <= 1'b0;
        statusWr <= 1'b0;
        wrCommit <= 1'b0;
        if (sRise) bitCnt <= bitCnt + 3'd1;
        if (sFall && outPhase) outCnt <= outCnt + 3'd1;
        if (byteDone) begin
          case (state)
            ST_IDLE: begin
              if (busy && nextByte != OP_RDSR) state <= ST_IGNORE;
              else begin
                case (nextByte)
                  OP_RDSR:  begin state <= ST_STATUS; statusRd <= 1'b1; end
                  OP_READ:  begin state <= ST_ADDR; isWrite <= 1'b0; end
                  OP_WRITE: begin state <= ST_ADDR; isWrite <= 1'b1; end
                  OP_WREN:  state <= ST_WREN_WAIT;
                  OP_WRDI:  begin state <= ST_IGNORE; wenClr <= 1'b1; end
                  OP_WRSR:  state <= ST_WRSR;
                  default:  state <= ST_IGNORE;
                endcase
              end
            end
            ST_ADDR: begin
              if (abCnt == LAST_AB) state <= isWrite ? ST_WDATA : ST_RDATA;
              else abCnt <= abCnt + ABW'(1);
            end
            ST_WDATA: begin wrValid <= 1'b1; gotByte <= 1'b1; end
            ST_WRSR:  state <= ST_SRDONE;
            default:  ;
          endcase
        end else if (sRise && (state == ST_WREN_WAIT || state == ST_SRDONE)) begin
          state <= ST_IGNORE;
        end
      end
    end
  end

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wenSet, wenClr, statusRd, statusWr, wrCommit, wrValid}));

  assert_wen_after_deselect_R6: assert property (@(posedge clk) disable iff (!rstN)
    wenSet |-> $past(csN));

  assert_commit_after_deselect_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> $past(csN));

  assert_hold_freezes_R11: assert property (@(posedge clk) disable iff (!rstN)
    (held && !csN) ##1 !csN |-> $stable(bitCnt) && $stable(outCnt));

  assert_busy_blocks_clear_R13: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && state == ST_IDLE && busy) |=> !wenClr);

endmodule

// File: rtl/spi_mem_cmd.sv
module spi_mem_cmd
  import spimem_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  input  logic              holdN,
  input  logic              busy,
  input  logic [7:0]        memRdData,
  input  logic [7:0]        statusIn,
  output logic              so,
  output logic              soEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              wrValid,
  output logic [7:0]        wrData,
  output logic              wrCommit,
  output logic              wenSet,
  output logic              wenClr,
  output logic              statusRd,
  output logic              statusWr
);

  localparam int ADDR_BYTES = (ADDR_W + BYTE_W - 1) / BYTE_W;

  dpStrobe_t         strb;
  logic [BYTE_W-1:0] nextByte;

  spimem_ctrl #(.ADDR_BYTES(ADDR_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .holdN(holdN), .busy(busy),
    .nextByte(nextByte), .strb(strb), .soEn(soEn), .wrValid(wrValid),
    .wrCommit(wrCommit), .wenSet(wenSet), .wenClr(wenClr),
    .statusRd(statusRd), .statusWr(statusWr)
  );

  spimem_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .si(si), .strb(strb), .memRdData(memRdData),
    .statusIn(statusIn), .nextByte(nextByte), .memAddr(memAddr), .so(so),
    .wrData(wrData)
  );

endmodule

// File: tb/tb_spi_mem_cmd.sv
module tb_spi_mem_cmd;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, si = 1'b0, holdN = 1'b1, busy = 1'b0;
  logic [7:0]  memRdData;
  logic [7:0]  statusIn = 8'hC3;
  logic        so, soEn, wrValid, wrCommit, wenSet, wenClr, statusRd, statusWr;
  logic [14:0] memAddr;
  logic [7:0]  wrData;

  int nChecks = 0, nFail = 0;
  int cWenSet = 0, cWenClr = 0, cStRd = 0, cStWr = 0, cCommit = 0;
  int wrA[$];
  int wrD[$];
  bit mode3 = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] memF(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b0} ^ 8'h5A;
  endfunction

  assign memRdData = memF(memAddr);

  spi_mem_cmd dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .busy(busy), .memRdData(memRdData), .statusIn(statusIn), .so(so),
    .soEn(soEn), .memAddr(memAddr), .wrValid(wrValid), .wrData(wrData),
    .wrCommit(wrCommit), .wenSet(wenSet), .wenClr(wenClr),
    .statusRd(statusRd), .statusWr(statusWr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock monitor: event capture plus the deselect rule R3
  always @(negedge clk) begin
    if (rstN) begin
      cWenSet += int'(wenSet);
      cWenClr += int'(wenClr);
      cStRd   += int'(statusRd);
      cStWr   += int'(statusWr);
      cCommit += int'(wrCommit);
      if (wrValid) begin wrA.push_back(int'(memAddr)); wrD.push_back(int'(wrData)); end
      chk(!(csN && soEn), "R3 soEn while deselected", int'(soEn), 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csLow();
    sck = mode3; si = 1'b0; tick(2);
    csN = 1'b0; tick(2);
  endtask

  task automatic csHigh();
    if (!mode3) begin sck = 1'b0; tick(2); end
    csN = 1'b1; tick(3);
  endtask

  // one bit: falling edge, settle, optional pause, sample, rising edge
  task automatic bitIo(input bit b, input bit doHold, output bit smp, output bit en);
    sck = 1'b0; si = b; tick(2);
    if (doHold) begin
      holdN = 1'b0; tick(2);
      chk(soEn == 1'b0, "R11 soEn while paused", int'(soEn), 0);
      repeat (2) begin
        sck = 1'b1; si = ~si; tick(2);
        sck = 1'b0; si = ~si; tick(2);
      end
      holdN = 1'b1; si = b; tick(2);
    end
    smp = so; en = soEn;
    sck = 1'b1; tick(2);
  endtask

  task automatic sendByte(input logic [7:0] b, input int holdAt = -1);
    for (int i = 7; i >= 0; i--) begin
      bit s, e;
      bitIo(b[i], (i == holdAt), s, e);
    end
  endtask

  task automatic readByte(input logic [7:0] exp, input string req, input int holdAt = -1);
    logic [7:0] got = '0;
    bit enAll = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit s, e;
      bitIo(1'b0, (i == holdAt), s, e);
      got[i] = s;
      enAll &= e;
    end
    chk(enAll, {req, " soEn during output"}, int'(enAll), 1);
    chk(got == exp, req, int'(got), int'(exp));
  endtask

  task automatic silentBits(input int n, input string req);
    bit anyEn = 1'b0;
    for (int i = 0; i < n; i++) begin
      bit s, e;
      bitIo(1'b1, 1'b0, s, e);
      anyEn |= e;
    end
    chk(!anyEn, req, int'(anyEn), 0);
  endtask

  task automatic sendAddr(input logic [15:0] a);
    sendByte(a[15:8]);
    sendByte(a[7:0]);
  endtask

  initial begin
    int snap, snap2;
    tick(3);
    rstN = 1'b1;
    tick(2);
    // reset state
    chk(soEn == 1'b0, "R3 reset soEn", int'(soEn), 0);
    chk(memAddr == 15'd0, "R4 reset address", int'(memAddr), 0);
    chk({wrValid, wrCommit, wenSet, wenClr, statusRd, statusWr} == 6'd0,
        "R6 reset strobes", 0, 0);

    // R1 R2 R4 R14: mode 0 read, discarded top address bit set
    mode3 = 1'b0;
    csLow(); sendByte(8'h03); sendAddr(16'h9234);
    readByte(memF(15'h1234), "R4 read first byte mode0");
    readByte(memF(15'h1235), "R2 read second byte mode0");
    csHigh();
    chk(soEn == 1'b0, "R3 soEn after deselect", int'(soEn), 0);

    // R5 R14: mode 3 read across the top of the array
    mode3 = 1'b1;
    csLow(); sendByte(8'h03); sendAddr(16'h7FFE);
    readByte(memF(15'h7FFE), "R14 read mode3");
    readByte(memF(15'h7FFF), "R5 read last address");
    readByte(memF(15'h0000), "R5 read wraps to zero");
    csHigh();

    // R8: status read repeats statusIn
    snap = cStRd;
    csLow(); sendByte(8'h05);
    readByte(8'hC3, "R8 status byte first");
    statusIn = 8'h3C;
    readByte(8'h3C, "R8 status byte repeated");
    csHigh();
    chk(cStRd == snap + 1, "R8 statusRd pulse count", cStRd - snap, 1);
    statusIn = 8'hC3;

    // R6: write enable only after deselect, and only for exactly 8 bits
    mode3 = 1'b0;
    snap = cWenSet;
    csLow(); sendByte(8'h06); tick(4);
    chk(cWenSet == snap, "R6 no wenSet before deselect", cWenSet - snap, 0);
    csHigh();
    chk(cWenSet == snap + 1, "R6 wenSet after deselect", cWenSet - snap, 1);
    snap = cWenSet;
    csLow(); sendByte(8'h06); silentBits(1, "R6 extra bit no output"); csHigh();
    chk(cWenSet == snap, "R6 extra bit cancels", cWenSet - snap, 0);

    // R7: clear enable pulses after opcode
    snap = cWenClr;
    csLow(); sendByte(8'h04); tick(2);
    chk(cWenClr == snap + 1, "R7 wenClr before deselect", cWenClr - snap, 1);
    csHigh();

    // R9: status write full byte, then short byte
    snap = cStWr;
    csLow(); sendByte(8'h01); sendByte(8'h8C); csHigh();
    chk(cStWr == snap + 1, "R9 statusWr pulse", cStWr - snap, 1);
    chk(wrData == 8'h8C, "R9 status data", int'(wrData), 8'h8C);
    snap = cStWr;
    csLow(); sendByte(8'h01); silentBits(4, "R9 partial no output"); csHigh();
    chk(cStWr == snap, "R9 partial byte rejected", cStWr - snap, 0);

    // R10: write two bytes, mode 3, pause inside the second (R11)
    mode3 = 1'b1;
    wrA.delete(); wrD.delete();
    snap = cCommit;
    csLow(); sendByte(8'h02); sendAddr(16'h0100);
    sendByte(8'hAA); sendByte(8'h55, 4);
    csHigh();
    chk(wrA.size() == 2, "R10 byte strobe count", wrA.size(), 2);
    if (wrA.size() == 2) begin
      chk(wrA[0] == 'h100 && wrD[0] == 'hAA, "R10 first byte", wrD[0], 'hAA);
      chk(wrA[1] == 'h101 && wrD[1] == 'h55, "R11 byte across pause", wrD[1], 'h55);
    end
    chk(cCommit == snap + 1, "R10 commit on boundary", cCommit - snap, 1);

    // R10: partial trailing byte, no commit
    wrA.delete(); wrD.delete();
    snap = cCommit;
    csLow(); sendByte(8'h02); sendAddr(16'h0200);
    sendByte(8'h11); silentBits(3, "R10 write no output"); csHigh();
    chk(wrA.size() == 1, "R10 one byte accepted", wrA.size(), 1);
    chk(cCommit == snap, "R10 no commit mid-byte", cCommit - snap, 0);

    // R11: pause mid-byte during a mode 0 read
    mode3 = 1'b0;
    csLow(); sendByte(8'h03); sendAddr(16'h0345);
    readByte(memF(15'h0345), "R11 read across pause", 3);
    readByte(memF(15'h0346), "R11 read continues");
    csHigh();

    // R12: unknown opcode
    snap = cWenSet + cWenClr + cStRd + cStWr + cCommit;
    csLow(); sendByte(8'hFF); silentBits(16, "R12 unknown opcode silent"); csHigh();
    snap2 = cWenSet + cWenClr + cStRd + cStWr + cCommit;
    chk(snap2 == snap, "R12 no strobes", snap2 - snap, 0);

    // R13: busy blocks all but status read
    busy = 1'b1;
    snap = cWenSet;
    csLow(); sendByte(8'h06); csHigh();
    chk(cWenSet == snap, "R13 enable ignored when busy", cWenSet - snap, 0);
    csLow(); sendByte(8'h03); silentBits(24, "R13 read ignored when busy"); csHigh();
    csLow(); sendByte(8'h05); readByte(8'hC3, "R13 status read when busy"); csHigh();
    busy = 1'b0;

    // R3: deselect mid-read, then a fresh command
    csLow(); sendByte(8'h03); sendAddr(16'h0010);
    sendByte(8'h00);
    csN = 1'b1; tick(3);
    chk(soEn == 1'b0, "R3 output off after abort", int'(soEn), 0);
    sck = 1'b0; tick(2);
    csLow(); sendByte(8'h03); sendAddr(16'h0020);
    readByte(memF(15'h0020), "R3 new command after abort");
    csHigh();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule